// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This block drives a three-wire serial EEPROM organised as 64 words of 16 bits. It owns the chip-select, serial-clock and serial-data-out pins and samples the memory's serial-data-in pin. A request port takes one read or one write at a time, with a 6-bit word address and 16-bit write data. The block answers with the read word, a one-cycle done pulse and a timeout flag.

Every pin step is held for `PHASE_CYCLES` system clocks. With a 100 MHz clock the default of 5000 gives 50 µs. A read is a start-and-opcode frame followed by the address, then 16 clocked-in data bits, and it closes with a standby toggle. A write is wrapped in a write-enable frame and a write-disable frame. Programming is started with a chip-select toggle, and the block then polls the memory's ready level a bounded number of times before it shuts the interface down with a final clock pulse.

Top module: `mw_eeprom_master`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `err` are all 0.
- R2: While busy, the pin outputs change only at multiples of `PHASE_CYCLES` clocks after acceptance. Every pin step lasts a whole number of phase intervals.
- R3: Serial fields leave MSB first. For each bit, `ee_di` is set first, then `ee_sk` rises, then `ee_sk` falls, one phase apart. `ee_di` never changes while `ee_sk` is high.
- R4: A read sends 110 followed by the 6 address bits. It then clocks in 16 bits, sampling `ee_do` at the end of each high clock phase, MSB first, with `ee_di` at 0. `done` arrives exactly 66 phases after acceptance, and `ee_cs` is left high.
- R5: Each access begins with `ee_sk` and `ee_di` low for one phase, and then `ee_cs` is driven high.
- R6: A standby toggle is four phases: `ee_cs` and `ee_sk` low, then `ee_sk` high, then `ee_cs` high, then `ee_sk` low. A read uses it once and a write uses it three times.
- R7: A write sends enable 10011 plus four 0 bits, then a standby. It then sends 101, the 6 address bits and the 16 data bits, so that the word is stored.
- R8: After the write data and a standby, `ee_do` is sampled once per phase. The first high sample ends the poll, and `err` stays 0.
- R9: If `ee_do` stays low for `POLL_LIMIT` samples, `err` is 1 together with `done`. `done` then arrives exactly 149 + `POLL_LIMIT` phases after acceptance.
- R10: After the poll, a write performs a standby and sends disable 10000 plus four 0 bits. It ends with `ee_cs` and `ee_di` low and one full `ee_sk` pulse, leaving `ee_cs` low.
- R11: `ee_di` is 0 after every shift-out and at every `done`.
- R12: A request is accepted only while idle. `busy` is 1 from the cycle after acceptance until `done`, and a request made while busy has no effect.
- R13: `err` is cleared when the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Write ready-poll timed out |
| rdata | output | DATA_W | Last word read |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data / ready from the memory |

## Verification
Acceptance happens on the clock edge that sees `req_valid` while the block is idle, and `busy` is visible one cycle later. A read's `done` is due exactly 66 × `PHASE_CYCLES` cycles after that edge. A write takes 149 phases plus one phase per ready poll, which is exactly 349 phases when the poll times out. The bench counts falling edges from the acceptance edge and compares the count for reads and for timeouts. For writes that finish normally, which take a variable number of polls, it checks that the count lies within the 149 to 349 phase window. Pin-step spacing is checked continuously by a monitor, which confirms that each change falls a multiple of the phase interval after the previous one.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        K_IDLE,
        K_SETUP,
        K_SHOUT,
        K_SHIN,
        K_STBY,
        K_POLL,
        K_CLEAN,
        K_END
    } seg_kind_e;

    // Opcode patterns, start bit included
    localparam logic [2:0] OP_RD  = 3'b110;
    localparam logic [2:0] OP_WR  = 3'b101;
    localparam logic [4:0] OP_EN  = 5'b10011;
    localparam logic [4:0] OP_DIS = 5'b10000;

    localparam int SEG_W = 4;

endpackage

// File: rtl/mw_tick_timer.sv
module mw_tick_timer #(
    parameter int PHASE_CYCLES = 5000,
    localparam int CW = $clog2(PHASE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(PHASE_CYCLES - 1));

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PHASE_CYCLES - 1));

endmodule

// File: rtl/mw_frame_plan.sv
module mw_frame_plan
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    localparam int SH_W = 3 + ADDR_W + DATA_W,
    localparam int BCW  = $clog2(SH_W + 1)
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output seg_kind_e         kind,
    output logic [BCW-1:0]    nbits,
    output logic [SH_W-1:0]   word
);

    localparam int CMD_BITS = 3 + ADDR_W;

    // Words are left-aligned in the shift register
    logic [SH_W-1:0] w_rd, w_en, w_dis, w_wr;
    assign w_rd  = {OP_RD, addr, {DATA_W{1'b0}}};
    assign w_en  = {OP_EN, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    assign w_dis = {OP_DIS, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    assign w_wr  = {OP_WR, addr, wdata};

    always_comb begin
        kind  = K_END;
        nbits = '0;
        word  = '0;
        if (is_wr) begin
            case (seg)
                4'd0: kind = K_SETUP;
                4'd1: begin kind = K_SHOUT; nbits = BCW'(CMD_BITS); word = w_en;  end
                4'd2: kind = K_STBY;
                4'd3: begin kind = K_SHOUT; nbits = BCW'(SH_W);     word = w_wr;  end
                4'd4: kind = K_STBY;
                4'd5: kind = K_POLL;
                4'd6: kind = K_STBY;
                4'd7: begin kind = K_SHOUT; nbits = BCW'(CMD_BITS); word = w_dis; end
                4'd8: kind = K_CLEAN;
                default: kind = K_END;
            endcase
        end else begin
            case (seg)
                4'd0: kind = K_SETUP;
                4'd1: begin kind = K_SHOUT; nbits = BCW'(CMD_BITS); word = w_rd; end
                4'd2: kind = K_SHIN;
                4'd3: kind = K_STBY;
                default: kind = K_END;
            endcase
        end
    end

endmodule

// File: rtl/mw_engine.sv
module mw_engine
    import mw_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int POLL_LIMIT = 200,
    localparam int SH_W = 3 + ADDR_W + DATA_W,
    localparam int BCW  = $clog2(SH_W + 1),
    localparam int PCW  = $clog2(POLL_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tick,
    input  logic              ee_do,
    input  seg_kind_e         plan_kind,
    input  logic [BCW-1:0]    plan_bits,
    input  logic [SH_W-1:0]   plan_word,
    output logic [SEG_W-1:0]  plan_seg,
    output logic              cur_wr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di
);

    typedef struct packed {
        seg_kind_e         kind;
        logic [SEG_W-1:0]  seg;
        logic [1:0]        sub;
        logic [BCW-1:0]    bits;
        logic [SH_W-1:0]   sh;
        logic [DATA_W-1:0] rd;
        logic [PCW-1:0]    polls;
        logic              cs;
        logic              sk;
        logic              di;
        logic              busy;
        logic              done;
        logic              err;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } eng_t;

    eng_t q, d;
    logic adv;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        adv    = 1'b0;
        if (q.kind == K_IDLE) begin
            if (req_valid) begin
                d.busy  = 1'b1;
                d.err   = 1'b0;
                d.wr    = req_write;
                d.addr  = req_addr;
                d.wdata = req_wdata;
                d.seg   = '0;
                d.kind  = K_SETUP;
                d.sub   = 2'd0;
                d.sk    = 1'b0;
                d.di    = 1'b0;
            end
        end else if (tick) begin
            case (q.kind)
                K_SETUP: begin
                    if (q.sub == 2'd0) begin d.sub = 2'd1; d.cs = 1'b1; end
                    else adv = 1'b1;
                end
                K_SHOUT: begin
                    case (q.sub)
                        2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                        2'd1: begin d.sub = 2'd2; d.sk = 1'b0; end
                        2'd2: begin
                            if (q.bits == BCW'(1)) begin
                                d.sub = 2'd3;
                                d.di  = 1'b0;
                            end else begin
                                d.bits = q.bits - 1'b1;
                                d.sh   = q.sh << 1;
                                d.di   = q.sh[SH_W-2];
                                d.sub  = 2'd0;
                            end
                        end
                        default: adv = 1'b1;
                    endcase
                end
                K_SHIN: begin
                    if (q.sub == 2'd0) begin
                        d.rd  = {q.rd[DATA_W-2:0], ee_do};
                        d.sk  = 1'b0;
                        d.sub = 2'd1;
                    end else if (q.bits == BCW'(1)) begin
                        adv = 1'b1;
                    end else begin
                        d.bits = q.bits - 1'b1;
                        d.sk   = 1'b1;
                        d.sub  = 2'd0;
                    end
                end
                K_STBY: begin
                    case (q.sub)
                        2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                        2'd1: begin d.sub = 2'd2; d.cs = 1'b1; end
                        2'd2: begin d.sub = 2'd3; d.sk = 1'b0; end
                        default: adv = 1'b1;
                    endcase
                end
                K_POLL: begin
                    if (ee_do) begin
                        adv = 1'b1;
                    end else if (q.polls == PCW'(POLL_LIMIT - 1)) begin
                        d.err = 1'b1;
                        adv   = 1'b1;
                    end else begin
                        d.polls = q.polls + 1'b1;
                    end
                end
                K_CLEAN: begin
                    case (q.sub)
                        2'd0: begin d.sub = 2'd1; d.sk = 1'b1; end
                        2'd1: begin d.sub = 2'd2; d.sk = 1'b0; end
                        default: adv = 1'b1;
                    endcase
                end
                default: ;
            endcase

            if (adv) begin
                d.seg  = q.seg + 1'b1;
                d.kind = plan_kind;
                d.sub  = 2'd0;
                case (plan_kind)
                    K_SHOUT: begin
                        d.sh   = plan_word;
                        d.bits = plan_bits;
                        d.di   = plan_word[SH_W-1];
                    end
                    K_SHIN: begin
                        d.bits = BCW'(DATA_W);
                        d.sk   = 1'b1;
                        d.di   = 1'b0;
                    end
                    K_STBY: begin
                        d.cs = 1'b0;
                        d.sk = 1'b0;
                    end
                    K_POLL: d.polls = '0;
                    K_CLEAN: begin
                        d.cs = 1'b0;
                        d.di = 1'b0;
                    end
                    default: begin
                        d.kind = K_IDLE;
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.kind <= K_IDLE;
        end else begin
            q <= d;
        end
    end

    assign plan_seg  = q.seg + 1'b1;
    assign cur_wr    = q.wr;
    assign cur_addr  = q.addr;
    assign cur_wdata = q.wdata;
    assign busy      = q.busy;
    assign done      = q.done;
    assign err       = q.err;
    assign rdata     = q.rd;
    assign ee_cs     = q.cs;
    assign ee_sk     = q.sk;
    assign ee_di     = q.di;

    // R3
    di_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sk && $past(q.sk)) |-> (q.di == $past(q.di)));

    // R2
    pins_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({q.cs, q.sk, q.di} != $past({q.cs, q.sk, q.di}))
            |-> ($past(tick) || $past(q.kind == K_IDLE)));

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && q.kind == K_IDLE));

    // R9
    err_from_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> $past(q.kind == K_POLL));

    // R4
    shin_di_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.kind == K_SHIN) |-> !q.di);

    // R5
    setup_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.kind == K_SETUP && q.sub == 2'd1) |-> (q.cs && !q.sk && !q.di));

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16,
    parameter int PHASE_CYCLES = 5000,
    parameter int POLL_LIMIT   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);

    localparam int SH_W = 3 + ADDR_W + DATA_W;
    localparam int BCW  = $clog2(SH_W + 1);

    logic              tick;
    seg_kind_e         plan_kind;
    logic [BCW-1:0]    plan_bits;
    logic [SH_W-1:0]   plan_word;
    logic [SEG_W-1:0]  plan_seg;
    logic              cur_wr;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    mw_tick_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    mw_frame_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_plan (
        .seg   (plan_seg),
        .is_wr (cur_wr),
        .addr  (cur_addr),
        .wdata (cur_wdata),
        .kind  (plan_kind),
        .nbits (plan_bits),
        .word  (plan_word)
    );

    mw_engine #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .tick      (tick),
        .ee_do     (ee_do),
        .plan_kind (plan_kind),
        .plan_bits (plan_bits),
        .plan_word (plan_word),
        .plan_seg  (plan_seg),
        .cur_wr    (cur_wr),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di)
    );

endmodule

// File: tb/mw_eeprom_master_tb.sv
module mw_eeprom_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 3;
    localparam int POLLS      = 200;
    localparam int RD_PHASES  = 66;
    localparam int WR_BASE    = 149;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err;
    logic [15:0] rdata;
    logic        ee_cs, ee_sk, ee_di, ee_do;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_master #(.PHASE_CYCLES(DLY), .POLL_LIMIT(POLLS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    // ---------------- serial memory model ----------------
    logic [15:0] mem [0:63];
    logic        cs_p, sk_p, rd_act, wr_act, wr_pend, wen, dout;
    logic [8:0]  cmd;
    logic [5:0]  raddr, waddr;
    logic [15:0] wdat;
    logic [23:0] hist;
    int          nb, prog_left, di_err, stby;
    int          prog_cycles = 40;

    assign ee_do = rd_act ? dout : (prog_left == 0);

    always @(posedge clk) begin : model
        logic [8:0] c;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= 16'hC000 | 16'(i);
            cs_p <= 1'b0; sk_p <= 1'b0; rd_act <= 1'b0; wr_act <= 1'b0;
            wr_pend <= 1'b0; wen <= 1'b0; dout <= 1'b0; cmd <= '0;
            raddr <= '0; waddr <= '0; wdat <= '0; hist <= '0;
            nb <= 0; prog_left <= 0; di_err <= 0; stby <= 0;
        end else begin
            cs_p <= ee_cs;
            sk_p <= ee_sk;
            if (prog_left > 0) prog_left <= prog_left - 1;
            if (ee_cs && !cs_p && ee_sk) stby <= stby + 1;
            if (!ee_cs) begin
                nb <= 0; rd_act <= 1'b0; wr_act <= 1'b0;
                if (cs_p && wr_pend) begin
                    prog_left <= prog_cycles;
                    if (wen) mem[waddr] <= wdat;
                    wr_pend <= 1'b0;
                end
            end else if (ee_sk && !sk_p) begin
                if (nb == 0 && !ee_di) begin
                    nb <= 0;
                end else if (nb < 9) begin
                    c = {cmd[7:0], ee_di};
                    cmd <= c;
                    nb <= nb + 1;
                    if (nb == 8) begin
                        case (c[8:6])
                            3'b110: begin rd_act <= 1'b1; raddr <= c[5:0]; hist <= {hist[15:0], 8'h52}; end
                            3'b101: begin wr_act <= 1'b1; waddr <= c[5:0]; hist <= {hist[15:0], 8'h57}; end
                            3'b100: begin
                                if (c[5:4] == 2'b11) begin wen <= 1'b1; hist <= {hist[15:0], 8'h45}; end
                                if (c[5:4] == 2'b00) begin wen <= 1'b0; hist <= {hist[15:0], 8'h44}; end
                            end
                            default: ;
                        endcase
                    end
                end else begin
                    nb <= nb + 1;
                    if (nb <= 24) begin
                        if (rd_act) begin
                            dout <= mem[raddr][24-nb];
                            if (ee_di) di_err <= di_err + 1;
                        end
                        if (wr_act) begin
                            wdat <= {wdat[14:0], ee_di};
                            if (nb == 24) wr_pend <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // ---------------- pin-step spacing monitor (R2) ----------------
    int       cyc = 0, last_chg = 0, space_err = 0;
    logic [2:0] pins_p = '0;
    logic     busy_p = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        pins_p <= {ee_cs, ee_sk, ee_di};
        busy_p <= busy;
        if (busy && !busy_p) last_chg <= cyc;
        else if (busy && busy_p && ({ee_cs, ee_sk, ee_di} != pins_p)) begin
            if (((cyc - last_chg) % DLY) != 0) space_err <= space_err + 1;
            last_chg <= cyc;
        end
    end

    // ---------------- checking ----------------
    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit wr, input logic [5:0] a, input logic [15:0] d, input bit inject,
                          output int lat, output logic [15:0] rd, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R12 busy after accept", 32'(busy), 32'd1);
        check(err == 1'b0, "R13 err cleared on accept", 32'(err), 32'd0);
        check(!ee_sk && !ee_di, "R5 setup sk/di low", {30'd0, ee_sk, ee_di}, 32'd0);
        lat = 0;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
            if (lat == DLY) check(ee_cs == 1'b1, "R5 cs high after setup", 32'(ee_cs), 32'd1);
            if (inject && lat == 10) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd30; req_wdata = 16'h1234;
            end
            if (inject && lat == 11) req_valid = 1'b0;
        end
        if (lat >= 5000) check(1'b0, "watchdog op", 32'(lat), 32'd0);
        rd = rdata;
        e  = err;
        check(!busy, "R12 busy low at done", 32'(busy), 32'd0);
        check(!ee_di, "R11 di low at done", 32'(ee_di), 32'd0);
        @(negedge clk);
        check(!done, "R12 done one cycle", 32'(done), 32'd0);
    endtask

    // {write, addr, data, expected}
    localparam logic [38:0] VEC [8] = '{
        {1'b1, 6'd0,  16'hA5C3, 16'hA5C3},
        {1'b1, 6'd63, 16'hFFFF, 16'hFFFF},
        {1'b1, 6'd21, 16'h0001, 16'h0001},
        {1'b0, 6'd0,  16'h0000, 16'hA5C3},
        {1'b0, 6'd63, 16'h0000, 16'hFFFF},
        {1'b0, 6'd21, 16'h0000, 16'h0001},
        {1'b0, 6'd5,  16'h0000, 16'hC005},
        {1'b0, 6'd42, 16'h0000, 16'hC02A}
    };

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        int lat, s0;
        logic [15:0] rd;
        logic e;
        repeat (3) @(negedge clk);
        // R1
        check({ee_cs, ee_sk, ee_di, busy, done, err} == 6'd0, "R1 reset state",
              {26'd0, ee_cs, ee_sk, ee_di, busy, done, err}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 8; i++) begin
            s0 = stby;
            run_op(VEC[i][38], VEC[i][37:32], VEC[i][31:16], 1'b0, lat, rd, e);
            if (VEC[i][38]) begin
                check(lat >= WR_BASE*DLY && lat < (WR_BASE+POLLS)*DLY, "R8 write latency", 32'(lat), 32'(WR_BASE*DLY));
                check(e == 1'b0, "R8 no timeout", 32'(e), 32'd0);
                check(hist == 24'h455744, "R7 R10 enable/write/disable frames", 32'(hist), 32'h455744);
                check(mem[VEC[i][37:32]] == VEC[i][15:0], "R7 word stored", 32'(mem[VEC[i][37:32]]), 32'(VEC[i][15:0]));
                check(wen == 1'b0, "R10 write disabled", 32'(wen), 32'd0);
                check(ee_cs == 1'b0 && ee_sk == 1'b0, "R10 cleanup pins", {30'd0, ee_cs, ee_sk}, 32'd0);
                check(stby - s0 == 3, "R6 write standby count", 32'(stby - s0), 32'd3);
            end else begin
                check(rd == VEC[i][15:0], "R4 R3 read data", 32'(rd), 32'(VEC[i][15:0]));
                check(lat == RD_PHASES*DLY, "R4 read latency", 32'(lat), 32'(RD_PHASES*DLY));
                check(hist[7:0] == 8'h52, "R4 read opcode", 32'(hist[7:0]), 32'h52);
                check(ee_cs == 1'b1, "R4 cs left high", 32'(ee_cs), 32'd1);
                check(stby - s0 == 1, "R6 read standby count", 32'(stby - s0), 32'd1);
                check(di_err == 0, "R4 di low while reading", 32'(di_err), 32'd0);
            end
        end

        // R12: request while busy has no effect
        run_op(1'b0, 6'd21, 16'h0, 1'b1, lat, rd, e);
        check(rd == 16'h0001, "R12 read unaffected by busy request", 32'(rd), 32'h0001);
        check(lat == RD_PHASES*DLY, "R12 latency unaffected", 32'(lat), 32'(RD_PHASES*DLY));
        run_op(1'b0, 6'd30, 16'h0, 1'b0, lat, rd, e);
        check(rd == 16'hC01E, "R12 busy-time write ignored", 32'(rd), 32'hC01E);

        // R9: timeout
        prog_cycles = 100000;
        run_op(1'b1, 6'd9, 16'h5A5A, 1'b0, lat, rd, e);
        check(e == 1'b1, "R9 timeout flagged with done", 32'(e), 32'd1);
        check(lat == (WR_BASE+POLLS)*DLY, "R9 timeout latency", 32'(lat), 32'((WR_BASE+POLLS)*DLY));
        check(hist == 24'h455744, "R10 disable after timeout", 32'(hist), 32'h455744);

        // R13: cleared by next request (checked at accept inside run_op)
        run_op(1'b0, 6'd42, 16'h0, 1'b0, lat, rd, e);
        check(e == 1'b0, "R13 err stays clear", 32'(e), 32'd0);
        check(rd == 16'hC02A, "R4 read after timeout", 32'(rd), 32'hC02A);

        // R2
        check(space_err == 0, "R2 pin step spacing", 32'(space_err), 32'd0);
        finish_run();
    end

endmodule